// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port. It moves one 8-bit byte at a time over a single bidirectional data line and always generates the shift clock itself. A one-cycle write strobe with a byte starts a transmit. Raising the receive enable starts a receive, as long as the receive-done flag is clear. The bit period is taken from the system clock divided by 4, 64 or 1024, as chosen by a two-bit select. The select is sampled when a transfer begins.

Bits travel least significant first in both directions. Each bit period starts with the shift clock going low, and that is when the port places a new transmit bit on the line or a peer places a new receive bit. Halfway through the bit the clock rises. At that rising edge the port captures incoming data. Each direction has a sticky done flag that stays set until its clear input is pulsed. While the receive-done flag is set, no reception happens. When the port is idle the shift clock rests high and the data line is released.

Top module: `sync_shift_port`

## Requirements
- R1: One bit lasts P system clocks. P is 4 when `clk_sel` is 0, 64 when it is 1, and 1024 when it is 2 or 3. The select is captured at the start of each transfer.
- R2: A `wr_en` pulse while idle starts a transmit of `wr_data`. The port drives `sd_oe` high and puts 8 bits on `sd_out`, bit 0 first. Each bit changes at the start of its period, which is when `sclk` falls.
- R3: `tx_done` rises at the clock edge 8·P cycles after the edge that accepted the write, in the same cycle that `sd_oe` drops. It stays set until `tx_done_clr` is seen. If a set and a clear arrive in the same cycle, the set wins.
- R4: While idle with no write, `rx_en`=1 and `rx_done`=0 start a receive, and `sclk` toggles for 8 bit periods.
- R5: During a receive, `sd_in` is captured at each rising edge of `sclk`. The first captured bit becomes bit 0 of the byte.
- R6: At the eighth rising edge of `sclk`, `rx_done` is set and the assembled byte appears on `rd_data`.
- R7: While `rx_done` is 1, no receive starts and `sclk` stays high. The flag is cleared only by `rx_done_clr`, and reception then resumes if `rx_en` is 1.
- R8: `rd_data` changes only when a receive completes. A transmit leaves it unchanged.
- R9: While idle, `sclk` is 1 and `sd_oe` is 0.
- R10: A `wr_en` pulse during a transfer is ignored. The current byte completes unchanged and no second transmit follows.
- R11: If `wr_en` and a valid receive start occur in the same cycle, the transmit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 2 | Bit-period divider select |
| wr_en | input | 1 | Transmit byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last received byte |
| rx_en | input | 1 | Receive enable |
| tx_done | output | 1 | Transmit-complete flag |
| tx_done_clr | input | 1 | Clears `tx_done` |
| rx_done | output | 1 | Receive-complete flag |
| rx_done_clr | input | 1 | Clears `rx_done` |
| sd_oe | output | 1 | Data line output enable |
| sd_out | output | 1 | Data line output value |
| sd_in | input | 1 | Data line input value |
| sclk | output | 1 | Shift clock output |

## Verification
Two pairs of events can fall on the same clock edge.

- **Flag set and software clear.** The bench holds `tx_done_clr` high for the whole transmit. At the final edge, the set must win: the flag reads 1 for exactly one cycle and 0 on the next.
- **Transmit write and receive start.** The bench raises `wr_en` and `rx_en` in the same cycle while `rx_done` is clear. The port must shift the written byte out, leave `rx_done` at 0 and leave `rd_data` as it was.

Write strobes in the middle of a byte and receive enables held while `rx_done` is set are judged by counting `sclk` rising edges and by reading back the bytes that were shifted.

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int W        = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 64,
  parameter int DIV_SLOW = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   clk_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         rx_en,
  output logic         tx_done,
  input  logic         tx_done_clr,
  output logic         rx_done,
  input  logic         rx_done_clr,
  output logic         sd_oe,
  output logic         sd_out,
  input  logic         sd_in,
  output logic         sclk
);
  localparam int CW = $clog2(DIV_SLOW);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_TX = 2'd1, S_RX = 2'd2} st_t;

  st_t           st;
  logic [CW-1:0] cnt, pm1;
  logic [BW-1:0] bitn;
  logic [W-1:0]  sh;

  function automatic logic [CW-1:0] pm1_of(input logic [1:0] s);
    case (s)
      2'd0:    return CW'(DIV_FAST - 1);
      2'd1:    return CW'(DIV_MID - 1);
      default: return CW'(DIV_SLOW - 1);
    endcase
  endfunction

  wire [CW-1:0] hm      = pm1 >> 1;
  wire          at_end  = (cnt == pm1);
  wire          at_rise = (cnt == hm);
  wire          tx_fin  = (st == S_TX) && at_end && (bitn == LAST_BIT);
  wire          rx_fin  = (st == S_RX) && at_rise && (bitn == LAST_BIT);
  wire [W-1:0]  rx_next = {sd_in, sh[W-1:1]};

  assign sd_oe  = (st == S_TX);
  assign sd_out = sd_oe & sh[0];
  assign sclk   = (st == S_IDLE) ? 1'b1 : (cnt > hm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (tx_fin)           tx_done <= 1'b1;
      else if (tx_done_clr) tx_done <= 1'b0;
      if (rx_fin)           rx_done <= 1'b1;
      else if (rx_done_clr) rx_done <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      pm1     <= '0;
      bitn    <= '0;
      sh      <= '0;
      rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt  <= '0;
          bitn <= '0;
          if (wr_en) begin
            sh  <= wr_data;
            pm1 <= pm1_of(clk_sel);
            st  <= S_TX;
          end else if (rx_en && !rx_done) begin
            pm1 <= pm1_of(clk_sel);
            st  <= S_RX;
          end
        end
        S_TX: begin
          cnt <= at_end ? '0 : cnt + 1'b1;
          if (at_end) begin
            sh   <= sh >> 1;
            bitn <= bitn + 1'b1;
            if (bitn == LAST_BIT) st <= S_IDLE;
          end
        end
        S_RX: begin
          cnt <= at_end ? '0 : cnt + 1'b1;
          if (at_rise) begin
            sh   <= rx_next;
            bitn <= bitn + 1'b1;
            if (bitn == LAST_BIT) begin
              rd_data <= rx_next;
              st      <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sync_shift_port_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         tx_done,
  input logic         tx_done_clr,
  input logic         rx_done,
  input logic         sd_oe,
  input logic         sclk,
  input logic [W-1:0] rd_data,
  input logic [1:0]   st
);
  AST_OE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> $past(wr_en)); // R2
  AST_TX_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $fell(sd_oe)); // R3
  AST_TX_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_done_clr) |=> tx_done); // R3
  AST_RX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (st != 2'd2)); // R7
  AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rx_done) |-> $stable(rd_data)); // R8
  AST_RX_DONE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> sclk); // R6
endmodule

bind sync_shift_port sync_shift_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx_done(tx_done),
  .tx_done_clr(tx_done_clr), .rx_done(rx_done), .sd_oe(sd_oe),
  .sclk(sclk), .rd_data(rd_data), .st(st)
);

// File: tb/sim_sync_shift_port.sv
`timescale 1ns/1ps
module sim_sync_shift_port;
  logic clk = 0, rst_n = 0;
  logic [1:0] clk_sel = 0;
  logic wr_en = 0, rx_en = 0, tx_done_clr = 0, rx_done_clr = 0, sd_in = 1;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic tx_done, rx_done, sd_oe, sd_out, sclk;
  int checks = 0, errors = 0;
  int rises = 0;
  logic [7:0] txcap = 0;

  always #10 clk = ~clk;

  sync_shift_port u0 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rx_en(rx_en), .tx_done(tx_done), .tx_done_clr(tx_done_clr),
    .rx_done(rx_done), .rx_done_clr(rx_done_clr), .sd_oe(sd_oe), .sd_out(sd_out),
    .sd_in(sd_in), .sclk(sclk)
  );

  always @(posedge sclk) begin
    rises++;
    if (sd_oe) txcap = {sd_out, txcap[7:1]};
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int period(input logic [1:0] s);
    return (s == 0) ? 4 : (s == 1) ? 64 : 1024;
  endfunction

  task automatic clear_flags();
    @(negedge clk); tx_done_clr = 1; rx_done_clr = 1;
    @(negedge clk); tx_done_clr = 0; rx_done_clr = 0;
  endtask

  task automatic do_tx(input logic [7:0] b, input logic [1:0] s, input string tag);
    int n = 0, r0;
    clear_flags();
    r0 = rises;
    @(negedge clk); wr_data = b; clk_sel = s; wr_en = 1;
    @(negedge clk); wr_en = 0;
    while (!tx_done && n < 9000) begin @(negedge clk); n++; end
    chk(n == 8 * period(s), {tag, " R1 R3 cycles to tx_done"}, n, 8 * period(s));
    chk(txcap == b, {tag, " R2 shifted byte"}, txcap, b);
    chk(rises - r0 == 8, {tag, " R2 sclk rises"}, rises - r0, 8);
    chk(sclk && !sd_oe, {tag, " R9 idle after tx"}, {sclk, sd_oe}, 2);
  endtask

  task automatic do_rx(input logic [7:0] b, input logic [1:0] s, input string tag);
    int n = 0, r0;
    r0 = rises;
    fork
      begin
        for (int i = 0; i < 8; i++) begin @(negedge sclk); sd_in = b[i]; end
      end
    join_none
    @(negedge clk); clk_sel = s; rx_en = 1;
    while (!rx_done && n < 9000) begin @(negedge clk); n++; end
    rx_en = 0;
    chk(rx_done, {tag, " R4 R6 rx_done set"}, rx_done, 1);
    chk(rd_data == b, {tag, " R5 R6 received byte"}, rd_data, b);
    chk(rises - r0 == 8, {tag, " R4 sclk rises"}, rises - r0, 8);
    chk(sclk && !sd_oe, {tag, " R9 idle after rx"}, {sclk, sd_oe}, 2);
  endtask

  task automatic t_reset();
    chk(sclk == 1, "R9 reset sclk", sclk, 1);
    chk(sd_oe == 0, "R9 reset sd_oe", sd_oe, 0);
    chk(!tx_done && !rx_done, "R3 R6 reset flags", {tx_done, rx_done}, 0);
    chk(rd_data == 0, "R8 reset rd_data", rd_data, 0);
  endtask

  task automatic t_modes();
    do_tx(8'hA5, 2'd0, "mode0");
    do_tx(8'h01, 2'd0, "mode0 lsb");
    do_tx(8'h3C, 2'd1, "mode1");
    do_tx(8'hC3, 2'd2, "mode2");
    do_tx(8'h80, 2'd3, "mode3");
  endtask

  task automatic t_tx_ignored();
    int r0, n = 0;
    clear_flags();
    @(negedge clk); wr_data = 8'h96; clk_sel = 0; wr_en = 1;
    @(negedge clk); wr_en = 0;
    repeat (9) @(negedge clk);
    wr_data = 8'h5A; wr_en = 1;
    @(negedge clk); wr_en = 0;
    while (!tx_done && n < 200) begin @(negedge clk); n++; end
    chk(txcap == 8'h96, "R10 byte unchanged by busy write", txcap, 8'h96);
    r0 = rises;
    repeat (50) @(negedge clk);
    chk(rises == r0 && !sd_oe, "R10 no second transmit", rises - r0, 0);
  endtask

  task automatic t_set_clear_same();
    int n = 0;
    clear_flags();
    @(negedge clk); wr_data = 8'h11; clk_sel = 0; wr_en = 1; tx_done_clr = 1;
    @(negedge clk); wr_en = 0;
    while (!tx_done && n < 200) begin @(negedge clk); n++; end
    chk(tx_done && n == 32, "R3 set wins over clear", n, 32);
    @(negedge clk);
    chk(!tx_done, "R3 clear after set", tx_done, 0);
    tx_done_clr = 0;
  endtask

  task automatic t_rx();
    clear_flags();
    do_rx(8'h6B, 2'd0, "rx mode0");
    clear_flags();
    do_rx(8'hD2, 2'd1, "rx mode1");
  endtask

  task automatic t_frozen();
    int r0;
    logic [7:0] keep;
    keep = rd_data;
    r0 = rises;
    @(negedge clk); rx_en = 1;
    repeat (100) @(negedge clk);
    chk(rises == r0 && sclk, "R7 no receive while rx_done", rises - r0, 0);
    chk(rd_data == keep, "R7 rd_data frozen", rd_data, keep);
    rx_en = 0;
    clear_flags();
    do_rx(8'h4E, 2'd0, "R7 resume");
  endtask

  task automatic t_tx_keeps_rd();
    logic [7:0] keep;
    keep = rd_data;
    do_tx(8'hFF, 2'd0, "R8 tx");
    chk(rd_data == keep, "R8 rd_data kept across tx", rd_data, keep);
  endtask

  task automatic t_priority();
    int n = 0;
    logic [7:0] keep;
    keep = rd_data;
    clear_flags();
    @(negedge clk); wr_data = 8'h2D; clk_sel = 0; wr_en = 1; rx_en = 1;
    @(negedge clk); wr_en = 0; rx_en = 0;
    chk(sd_oe, "R11 transmit taken", sd_oe, 1);
    while (!tx_done && n < 200) begin @(negedge clk); n++; end
    chk(txcap == 8'h2D && !rx_done, "R11 tx byte, no rx", txcap, 8'h2D);
    chk(rd_data == keep, "R11 rd_data unchanged", rd_data, keep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_modes();
    t_tx_ignored();
    t_set_clear_same();
    t_rx();
    t_frozen();
    t_tx_keeps_rd();
    t_priority();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    finish_run();
  end
endmodule